// File: doc/BRIEF.md
# Secure Memory Region Filter

This block decides whether a memory transaction may proceed, based on its address and on whether the requester is secure. Software programs up to nine windows through a small APB-style register port. The lookup port is purely combinational. It takes an address, a secure flag and a write flag. It returns a permit bit and the index of the window that made the decision.

Window 0 is a fixed background that spans the whole address space. Only its permission bits can be written. Every other window is a naturally aligned power-of-two range with an enable bit. Each window is cut into eight equal slices, and each slice can be removed from the window by its own disable bit.

A global inversion switch chooses how the permission bits are read. With the switch off, secure accesses always pass. With it on, all four permission bits apply.

Top module: `mem_region_filter`

## Requirements
- R1: The word at offset 0x000 is read-only. Bits [3:0] hold the number of windows minus one and bits [21:16] hold the address width minus one. Every other bit reads zero, and writes to this word change nothing.
- R2: Window n (n ≥ 1) has three words. The base low word is at 0x100+16n, the base high word at 0x104+16n and the attribute word at 0x108+16n. The base is stored as address-width bits. When the base is read back, the bits above the address width read zero.
- R3: Attribute bits [6:1] hold the size code k, which selects a window of 2^(k+1) bytes. A written code is clamped to the range MIN_SZ..ADDR_W-1 (14..39 by default), and the clamped value is what reads back.
- R4: An address lies inside window n when the address bits at and above position k+1 equal the same bits of the base. Base bits below position k+1 have no effect on matching.
- R5: Attribute bits [15:8] are slice-disable bits. The slice index is address bits [k:k-2]. An address in a disabled slice does not match that window.
- R6: Attribute bit [0] enables window n. A window whose enable bit is clear never matches.
- R7: Window 0 always reads base 0, size code ADDR_W-1, enable 1 and no disabled slices. Writes to its base words and to those attribute fields are ignored. Only its attribute bits [31:28] are writable.
- R8: When several windows match, the highest-numbered one decides, and its index appears on lk_region. Window 0 decides only when no other window matches.
- R9: Attribute bits [31:28] allow, in order from bit 28 to bit 31: secure read, secure write, non-secure read and non-secure write. When inversion is off, every secure access is permitted, and a non-secure access is permitted only by bit 30 (read) or bit 31 (write).
- R10: Bit 0 of the word at offset 0x004 is the inversion switch. When it is set, secure reads and secure writes also need bit 28 or bit 29 respectively of the deciding window.
- R11: A register write takes effect at the clock edge that completes the access phase (psel, penable and pwrite all high). The lookup reflects the new value from the next cycle on. Before that edge the lookup still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | 12 | Register byte address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data (combinational) |
| lk_addr | input | ADDR_W | Address to be checked |
| lk_secure | input | 1 | Requester is secure |
| lk_write | input | 1 | Access is a write |
| lk_allow | output | 1 | Access permitted |
| lk_region | output | clog2(NUM_REGIONS) | Index of the deciding window |

## Verification
The hardest case to reach is an address that sits inside several overlapping windows at once, where the result depends on the priority order, the slice-disable bits and misaligned base bits all together. The stimulus sets up nested windows on purpose:
- a large window;
- a smaller window inside it with a garbage low base and two disabled slices;
- a full-space window that can be switched on and off;
- a window at the top of the address space, reached only through the high base word.

Directed probes cover each slice boundary in every security and direction combination, in both inversion modes. A long random phase then concentrates addresses in the nested range. A behavioural model compares both lookup outputs on every clock, including the cycle of each register write.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

   typedef struct packed {
      logic ns_wr;
      logic ns_rd;
      logic s_wr;
      logic s_rd;
   } perm_t;

   localparam int SZ_W   = 6;
   localparam int APB_AW = 12;
   localparam int SUB_N  = 8;

   localparam logic [3:0]        GRP_WINDOW = 4'h1;
   localparam logic [APB_AW-1:0] OFF_CFG    = 12'h000;
   localparam logic [APB_AW-1:0] OFF_INV    = 12'h004;

   typedef enum logic [1:0] {
      W_BASE_LO = 2'd0,
      W_BASE_HI = 2'd1,
      W_ATTR    = 2'd2,
      W_RSVD    = 2'd3
   } word_sel_e;

   function automatic logic [31:0] pack_attr(perm_t p, logic [SUB_N-1:0] sd,
                                             logic [SZ_W-1:0] sz, logic en);
      return {p, 12'd0, sd, 1'b0, sz, en};
   endfunction

endpackage

// File: rtl/mrf_regs.sv
module mrf_regs
   import mrf_pkg::*;
#(
   parameter int ADDR_W      = 40,
   parameter int NUM_REGIONS = 9,
   parameter int MIN_SZ      = 14
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  psel,
   input  logic                  penable,
   input  logic                  pwrite,
   input  logic [APB_AW-1:0]     paddr,
   input  logic [31:0]           pwdata,
   output logic [31:0]           prdata,
   output logic [ADDR_W-1:0]     base_o [NUM_REGIONS],
   output logic [SZ_W-1:0]       size_o [NUM_REGIONS],
   output logic [NUM_REGIONS-1:0] en_o,
   output logic [SUB_N-1:0]      sd_o   [NUM_REGIONS],
   output perm_t                 perm_o [NUM_REGIONS],
   output logic                  inv_o
);

   localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(ADDR_W - 1);
   localparam logic [SZ_W-1:0] SZ_MIN = SZ_W'(MIN_SZ);
   localparam logic [31:0]     CFG_WORD = 32'(NUM_REGIONS - 1) | (32'(ADDR_W - 1) << 16);

   logic      wr_acc;
   logic      in_win;
   logic [3:0] widx;
   word_sel_e wsel;
   logic      inv_q;

   assign wr_acc = psel & penable & pwrite;
   assign in_win = (paddr[11:8] == GRP_WINDOW);
   assign widx   = paddr[7:4];
   assign wsel   = word_sel_e'(paddr[3:2]);
   assign inv_o  = inv_q;

   wire unused_bits = ^{pwdata, paddr[1:0]};

   function automatic logic [SZ_W-1:0] clamp_sz(input logic [SZ_W-1:0] v);
      if (v < SZ_MIN)      return SZ_MIN;
      else if (v > SZ_MAX) return SZ_MAX;
      else                 return v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            inv_q <= 1'b0;
      else if (wr_acc && paddr == OFF_INV)   inv_q <= pwdata[0];
   end

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
      logic sel_w;
      perm_t perm_q;
      assign sel_w = wr_acc && in_win && (widx == 4'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        perm_q <= '0;
         else if (sel_w && wsel == W_ATTR)  perm_q <= perm_t'(pwdata[31:28]);
      end
      assign perm_o[r] = perm_q;

      if (r == 0) begin : g_bg
         assign base_o[r] = '0;
         assign size_o[r] = SZ_MAX;
         assign en_o[r]   = 1'b1;
         assign sd_o[r]   = '0;
      end else begin : g_prog
         logic [31:0]      lo_q;
         logic [SZ_W-1:0]  sz_q;
         logic             en_q;
         logic [SUB_N-1:0] sd_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q <= '0;
               sz_q <= SZ_MIN;
               en_q <= 1'b0;
               sd_q <= '0;
            end else if (sel_w) begin
               if (wsel == W_BASE_LO) lo_q <= pwdata;
               if (wsel == W_ATTR) begin
                  en_q <= pwdata[0];
                  sz_q <= clamp_sz(pwdata[6:1]);
                  sd_q <= pwdata[15:8];
               end
            end
         end

         if (ADDR_W > 32) begin : g_hi
            logic [ADDR_W-33:0] hi_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                          hi_q <= '0;
               else if (sel_w && wsel == W_BASE_HI) hi_q <= pwdata[ADDR_W-33:0];
            end
            assign base_o[r] = {hi_q, lo_q};
         end else begin : g_nohi
            assign base_o[r] = lo_q[ADDR_W-1:0];
         end

         assign size_o[r] = sz_q;
         assign en_o[r]   = en_q;
         assign sd_o[r]   = sd_q;
      end
   end

   always_comb begin
      logic [63:0] b64;
      prdata = '0;
      b64    = '0;
      if (paddr == OFF_CFG) begin
         prdata = CFG_WORD;
      end else if (paddr == OFF_INV) begin
         prdata = {31'd0, inv_q};
      end else if (in_win) begin
         for (int r = 0; r < NUM_REGIONS; r++) begin
            if (widx == 4'(r)) begin
               b64 = 64'(base_o[r]);
               case (wsel)
                  W_BASE_LO: prdata = b64[31:0];
                  W_BASE_HI: prdata = b64[63:32];
                  W_ATTR:    prdata = pack_attr(perm_o[r], sd_o[r], size_o[r], en_o[r]);
                  default:   prdata = '0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/mrf_win_match.sv
module mrf_win_match
   import mrf_pkg::*;
#(
   parameter int ADDR_W = 40
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SZ_W-1:0]   size,
   input  logic              en,
   input  logic [SUB_N-1:0]  sd,
   output logic              hit
);

   logic [SZ_W:0]     shamt;
   logic [ADDR_W-1:0] keep;
   logic              above_eq;
   logic [2:0]        sub;

   assign shamt    = {1'b0, size} + 7'd1;
   assign keep     = {ADDR_W{1'b1}} << shamt;
   assign above_eq = ((addr ^ base) & keep) == '0;
   assign sub      = 3'(addr >> (size - SZ_W'(2)));
   assign hit      = en & above_eq & ~sd[sub];

endmodule

// File: rtl/mrf_prio.sv
module mrf_prio
   import mrf_pkg::*;
#(
   parameter int NUM_REGIONS = 9,
   parameter int IDX_W       = 4
) (
   input  logic [NUM_REGIONS-1:0] hit,
   input  perm_t                  perm [NUM_REGIONS],
   output logic [IDX_W-1:0]       sel,
   output perm_t                  sel_perm
);

   always_comb begin
      sel      = '0;
      sel_perm = perm[0];
      for (int r = 0; r < NUM_REGIONS; r++) begin
         if (hit[r]) begin
            sel      = IDX_W'(r);
            sel_perm = perm[r];
         end
      end
   end

endmodule

// File: rtl/mem_region_filter.sv
module mem_region_filter
   import mrf_pkg::*;
#(
   parameter int ADDR_W      = 40,
   parameter int NUM_REGIONS = 9,
   parameter int MIN_SZ      = 14,
   localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [11:0]       paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_secure,
   input  logic              lk_write,
   output logic              lk_allow,
   output logic [IDX_W-1:0]  lk_region
);

   if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_aw
      $error("ADDR_W must lie in 32..64");
   end
   if (NUM_REGIONS < 2 || NUM_REGIONS > 9) begin : g_bad_nr
      $error("NUM_REGIONS must lie in 2..9");
   end
   if (MIN_SZ < 2 || MIN_SZ > ADDR_W - 1) begin : g_bad_min
      $error("MIN_SZ must lie in 2..ADDR_W-1");
   end

   logic [ADDR_W-1:0]      base_v [NUM_REGIONS];
   logic [SZ_W-1:0]        size_v [NUM_REGIONS];
   logic [NUM_REGIONS-1:0] en_vec;
   logic [SUB_N-1:0]       sd_v   [NUM_REGIONS];
   perm_t                  perm_v [NUM_REGIONS];
   logic                   inv_q;
   logic [NUM_REGIONS-1:0] hit_vec;
   perm_t                  sel_perm;
   logic                   perm_bit;

   mrf_regs #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .MIN_SZ(MIN_SZ)) u_regs (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .base_o(base_v), .size_o(size_v), .en_o(en_vec), .sd_o(sd_v),
      .perm_o(perm_v), .inv_o(inv_q)
   );

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
      mrf_win_match #(.ADDR_W(ADDR_W)) u_match (
         .addr(lk_addr), .base(base_v[r]), .size(size_v[r]),
         .en(en_vec[r]), .sd(sd_v[r]), .hit(hit_vec[r])
      );
   end

   mrf_prio #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_prio (
      .hit(hit_vec), .perm(perm_v), .sel(lk_region), .sel_perm(sel_perm)
   );

   always_comb begin
      case ({lk_secure, lk_write})
         2'b11:   perm_bit = sel_perm.s_wr;
         2'b10:   perm_bit = sel_perm.s_rd;
         2'b01:   perm_bit = sel_perm.ns_wr;
         default: perm_bit = sel_perm.ns_rd;
      endcase
   end

   assign lk_allow = (lk_secure & ~inv_q) | perm_bit;

endmodule

// File: rtl/mrf_chk.sv
module mrf_chk #(
   parameter int ADDR_W      = 40,
   parameter int NUM_REGIONS = 9,
   localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   psel,
   input logic                   penable,
   input logic                   pwrite,
   input logic [11:0]            paddr,
   input logic [31:0]            pwdata,
   input logic [31:0]            prdata,
   input logic                   lk_secure,
   input logic                   lk_allow,
   input logic [IDX_W-1:0]       lk_region,
   input logic [NUM_REGIONS-1:0] hit_vec,
   input logic [NUM_REGIONS-1:0] en_vec,
   input logic                   inv_q
);

   localparam logic [31:0] CFG_EXP = 32'(NUM_REGIONS - 1) | (32'(ADDR_W - 1) << 16);

   // R1
   cfg_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && paddr == 12'h000) |-> prdata == CFG_EXP);

   // R8
   region_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(lk_region) < NUM_REGIONS);

   // R8
   top_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec >> lk_region) == NUM_REGIONS'(1));

   // R6
   enabled_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_region != '0) |-> en_vec[lk_region]);

   // R9
   secure_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_secure && !inv_q) |-> lk_allow);

   // R11
   inv_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pwrite && paddr == 12'h004) |=> inv_q == $past(pwdata[0]));

endmodule

bind mem_region_filter mrf_chk #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .lk_secure(lk_secure),
   .lk_allow(lk_allow), .lk_region(lk_region), .hit_vec(hit_vec),
   .en_vec(en_vec), .inv_q(inv_q)
);

// File: tb/tb_mem_region_filter.sv
`timescale 1ns/1ps
module tb_mem_region_filter;
   localparam int AW = 40;
   localparam int NR = 9;
   localparam int MINS = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic psel = 0, penable = 0, pwrite = 0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [AW-1:0] lk_addr = '0;
   logic lk_secure = 0, lk_write = 0;
   logic lk_allow;
   logic [3:0] lk_region;

   int total = 0, bad = 0;
   bit cmp_on = 0;
   string cur_req = "R8";

   logic [63:0] m_base [NR];
   int          m_size [NR];
   bit          m_en   [NR];
   bit [7:0]    m_sd   [NR];
   bit [3:0]    m_perm [NR];
   bit          m_inv;

   always #10 clk = ~clk;

   mem_region_filter #(.ADDR_W(AW), .NUM_REGIONS(NR), .MIN_SZ(MINS)) dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .lk_addr(lk_addr),
      .lk_secure(lk_secure), .lk_write(lk_write), .lk_allow(lk_allow),
      .lk_region(lk_region)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int clampv(input int v);
      if (v < MINS) return MINS;
      if (v > AW - 1) return AW - 1;
      return v;
   endfunction

   function automatic void model_init();
      for (int r = 0; r < NR; r++) begin
         m_base[r] = 0; m_size[r] = (r == 0) ? AW - 1 : MINS;
         m_en[r] = (r == 0); m_sd[r] = 0; m_perm[r] = 0;
      end
      m_inv = 0;
   endfunction

   function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
      int r;
      if (a == 12'h004) m_inv = d[0];
      if (a[11:8] == 4'h1 && a[7:4] < NR) begin
         r = a[7:4];
         if (r == 0) begin
            if (a[3:2] == 2) m_perm[0] = d[31:28];
         end else begin
            case (a[3:2])
               0: m_base[r][31:0] = d;
               1: m_base[r][63:32] = d;
               2: begin
                  m_en[r] = d[0]; m_size[r] = clampv(int'(d[6:1]));
                  m_sd[r] = d[15:8]; m_perm[r] = d[31:28];
               end
               default: ;
            endcase
            m_base[r] = m_base[r] & ((64'd1 << AW) - 1);
         end
      end
   endfunction

   function automatic logic [31:0] model_read(input logic [11:0] a);
      int r;
      if (a == 12'h000) return 32'(NR - 1) | (32'(AW - 1) << 16);
      if (a == 12'h004) return {31'd0, m_inv};
      if (a[11:8] == 4'h1 && a[7:4] < NR) begin
         r = a[7:4];
         case (a[3:2])
            0: return m_base[r][31:0];
            1: return m_base[r][63:32];
            2: return {m_perm[r], 12'd0, m_sd[r], 1'b0, 6'(m_size[r]), m_en[r]};
            default: return 0;
         endcase
      end
      return 0;
   endfunction

   function automatic void ref_lookup(input logic [63:0] a, input bit sec, input bit wr,
                                      output int reg_o, output bit allow);
      int n, sub, ix;
      bit ok;
      reg_o = 0;
      for (int r = NR - 1; r >= 1; r--) begin
         if (reg_o == 0 && m_en[r]) begin
            n = m_size[r];
            ok = 1;
            if (n + 1 < AW && (a >> (n + 1)) != (m_base[r] >> (n + 1))) ok = 0;
            sub = int'((a >> (n - 2)) & 64'd7);
            if (m_sd[r][sub]) ok = 0;
            if (ok) reg_o = r;
         end
      end
      if (sec && !m_inv) allow = 1;
      else begin
         ix = sec ? (wr ? 1 : 0) : (wr ? 3 : 2);
         allow = m_perm[reg_o][ix];
      end
   endfunction

   // cycle-by-cycle comparison of both lookup outputs (R4 R5 R6 R8 R9 R10 R11)
   always @(negedge clk) begin
      int er;
      bit ea;
      #2;
      if (cmp_on) begin
         ref_lookup(64'(lk_addr), lk_secure, lk_write, er, ea);
         chk({cur_req, " region"}, longint'(lk_region), longint'(er));
         chk({cur_req, " allow"}, longint'(lk_allow), longint'(ea));
      end
   end

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0; model_write(a, d);
   endtask

   task automatic apb_rd(input logic [11:0] a, input string req);
      @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge clk); penable = 1; #1;
      chk(req, longint'(prdata), longint'(model_read(a)));
      @(negedge clk); psel = 0; penable = 0;
   endtask

   task automatic probe(input logic [63:0] a, input string req);
      cur_req = req;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         lk_addr = a[AW-1:0]; lk_secure = k[1]; lk_write = k[0];
      end
   endtask

   function automatic logic [11:0] wa(input int r, input int w);
      return 12'(12'h100 + r * 16 + w * 4);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model_init();
      repeat (3) @(negedge clk);
      rst_n = 1;
      cmp_on = 1;
      // reset state
      apb_rd(12'h000, "R1 cfg");
      apb_rd(wa(0, 2), "R7 bg attr");
      apb_rd(wa(1, 2), "R3 reset attr");
      probe(64'h12_3456_7890, "R9 background");
      // R1: write ignored
      apb_wr(12'h000, 32'hFFFF_FFFF);
      apb_rd(12'h000, "R1 write ignored");
      // R7: only perm of window 0 writable
      apb_wr(wa(0, 0), 32'hDEAD_0000);
      apb_wr(wa(0, 1), 32'h0000_00AB);
      apb_wr(wa(0, 2), 32'h5000_FF3E);
      apb_rd(wa(0, 0), "R7 base lo");
      apb_rd(wa(0, 1), "R7 base hi");
      apb_rd(wa(0, 2), "R7 attr");
      // window 1: 64 KiB at 0x10000, non-secure read only
      apb_wr(wa(1, 0), 32'h0001_0000);
      apb_wr(wa(1, 2), (32'h4 << 28) | (15 << 1) | 1);
      probe(64'h0_1234, "R4 w1 inside");
      probe(64'h2_0000, "R4 w1 outside");
      // window 2: 32 KiB at 0x18000 with garbage low bits, slices 0 and 2 off
      apb_wr(wa(2, 0), 32'h0001_8123);
      apb_wr(wa(2, 2), (32'hC << 28) | (32'h05 << 8) | (14 << 1) | 1);
      apb_rd(wa(2, 0), "R2 base lo");
      for (int s = 0; s < 8; s++) probe(64'h1_8000 + s * 64'h1000 + 64'h10, "R5 slices");
      probe(64'h1_7FFF, "R8 edge");
      // window 3: disabled full-space window (R6)
      apb_wr(wa(3, 2), (32'hF << 28) | (39 << 1));
      probe(64'h1_9000, "R6 disabled");
      apb_wr(wa(3, 2), (32'hF << 28) | (39 << 1) | 1);
      probe(64'h1_9000, "R8 full enabled");
      apb_wr(wa(3, 2), (32'hF << 28) | (39 << 1));
      // R3 clamp
      apb_wr(wa(4, 2), 32'h0000_007F);
      apb_rd(wa(4, 2), "R3 clamp high");
      apb_wr(wa(4, 2), 32'h0000_0002);
      apb_rd(wa(4, 2), "R3 clamp low");
      // window 8 at top of space via high word
      apb_wr(wa(8, 1), 32'hFFFF_FF80);
      apb_rd(wa(8, 1), "R2 base hi masked");
      apb_wr(wa(8, 2), (32'h4 << 28) | (35 << 1) | 1);
      probe(64'h80_0000_1000, "R2 high window");
      probe(64'h70_0000_1000, "R2 high miss");
      // R10 inversion
      apb_wr(12'h004, 32'h1);
      apb_rd(12'h004, "R10 inv read");
      probe(64'h1_0100, "R10 w1");
      probe(64'h1_9000, "R10 w2");
      probe(64'h0_0100, "R10 bg");
      apb_wr(wa(2, 2), (32'h2 << 28) | (14 << 1) | 1);
      probe(64'h1_8000, "R10 s write");
      // random phase
      cur_req = "R8 random";
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         lk_addr = (i % 7 == 0) ? {8'h80, 32'($urandom)} : AW'($urandom_range(0, 32'h3_FFFF));
         lk_secure = 1'($urandom); lk_write = 1'($urandom);
         if (i % 500 == 250) begin
            @(negedge clk);
            apb_wr(12'h004, {31'd0, 1'($urandom)});
            cur_req = "R11 random";
         end
      end
      @(negedge clk);
      cmp_on = 0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule